// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the clocked controller of a successive-approximation converter. It presents a trial code to an external digital-to-analog converter and receives a one-bit comparator decision in return. When a start request arrives while the block is idle, the trial code jumps to half scale and the active-low busy flag drops in that same cycle, before any clock edge. One clock edge later the first comparison is due, and after that one bit is resolved per edge, most significant bit first.

When the least significant bit has been decided, the finished code is copied into an output holding register and busy is released. Start requests that arrive while a conversion is running are ignored. The holding register keeps the previous result until the new conversion is complete. The block's clock stands in for the converter's conversion clock, and each rising edge of `clk` plays the part of a decision edge.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset `busy_n` is 1, `result` is 0 and `trial_code` is 0.
- R2: A `start_req` pulse while idle drives `busy_n` low and `trial_code` to half scale (bit WIDTH-1 set, all others clear) in that same cycle, before the next clock edge.
- R3: The half-scale code is held across the first clock edge after the request, and the most significant decision is taken at the second edge.
- R4: At each decision edge the bit under trial stays 1 if `cmp_above` is 1 and is cleared otherwise, and the next lower bit is set, so the second trial code is 0xC00 or 0x400 (default width).
- R5: Bits are resolved from most to least significant, one per edge, and the result is straight binary. With an ideal comparator (`cmp_above` = input > `trial_code`, so a tie clears the bit), input v yields v-1, or 0 when v is 0.
- R6: `result` keeps its previous value throughout a conversion. It takes the new code at the same edge that decides the least significant bit, and at that edge `busy_n` returns to 1.
- R7: With the request raised right after a clock edge, `busy_n` is low for exactly 13 clock periods (default width and settle setting).
- R8: A `start_req` pulse while a conversion runs has no effect: the conversion ends at the same edge and with the same result.
- R9: A request raised in the first cycle after busy is released starts a new conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; each rising edge is a decision edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Single-cycle conversion request |
| cmp_above | input | 1 | Comparator decision: 1 when the input exceeds the trial level |
| trial_code | output | WIDTH (12) | Code presented to the converter's DAC |
| busy_n | output | 1 | Low while a conversion is in progress |
| result | output | WIDTH (12) | Holding register with the last completed conversion |

## Verification
The bench raises the request just after a falling edge and counts falling edges from that point. The busy flag and the half-scale code are due within the request cycle itself. The unchanged half-scale code is due one falling edge later, and the 1/4 or 3/4 trial two edges later. The old result must still be present at the twelfth falling edge, and the new result with busy high is due at the thirteenth. Every sample is taken a falling edge or 1 ns after an input change, never at a rising edge, so each check falls in the cycle after the register that drives it has updated.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETTLE  = 2'd1,
      PH_RESOLVE = 2'd2
   } seq_phase_e;

   function automatic int unsigned idx_bits(input int unsigned width);
      return (width > 1) ? $clog2(width) : 1;
   endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
   import sar_seq_pkg::*;
#(
   parameter int unsigned WIDTH         = 12,
   parameter int unsigned SETTLE_CYCLES = 1,
   localparam int unsigned IDX_W        = idx_bits(WIDTH),
   localparam int unsigned SCNT_W       = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   output logic             busy_q,
   output logic             load_half,
   output logic             decide,
   output logic             done_stb,
   output logic [IDX_W-1:0] bit_idx
);

   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

   seq_phase_e       phase_q;
   logic [IDX_W-1:0] idx_q;

   assign busy_q    = (phase_q != PH_IDLE);
   assign load_half = (phase_q == PH_IDLE) && start_req;
   assign decide    = (phase_q == PH_RESOLVE);
   assign done_stb  = decide && (idx_q == '0);
   assign bit_idx   = idx_q;

   generate
      if (SETTLE_CYCLES == 1) begin : g_no_settle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= PH_IDLE;
               idx_q   <= '0;
            end else begin
               unique case (phase_q)
                  PH_IDLE: if (start_req) begin
                     phase_q <= PH_RESOLVE;
                     idx_q   <= TOP_IDX;
                  end
                  PH_RESOLVE: begin
                     if (idx_q == '0) phase_q <= PH_IDLE;
                     else             idx_q   <= idx_q - 1'b1;
                  end
                  default: phase_q <= PH_IDLE;
               endcase
            end
         end
      end else begin : g_settle
         logic [SCNT_W-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= PH_IDLE;
               idx_q   <= '0;
               wait_q  <= '0;
            end else begin
               unique case (phase_q)
                  PH_IDLE: if (start_req) begin
                     phase_q <= PH_SETTLE;
                     wait_q  <= SCNT_W'(SETTLE_CYCLES - 2);
                  end
                  PH_SETTLE: begin
                     if (wait_q == '0) begin
                        phase_q <= PH_RESOLVE;
                        idx_q   <= TOP_IDX;
                     end else begin
                        wait_q <= wait_q - 1'b1;
                     end
                  end
                  PH_RESOLVE: begin
                     if (idx_q == '0) phase_q <= PH_IDLE;
                     else             idx_q   <= idx_q - 1'b1;
                  end
                  default: phase_q <= PH_IDLE;
               endcase
            end
         end
      end
   endgenerate

   // R5: bits walk downward by exactly one position per edge
   a_r5_bit_order: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && idx_q != '0) |=> (decide && idx_q == $past(idx_q) - 1'b1));

   // R8: a running conversion never returns to the start of its sequence
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && idx_q != TOP_IDX) |=> (phase_q != PH_SETTLE && idx_q != TOP_IDX));

endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial
   import sar_seq_pkg::*;
#(
   parameter int unsigned WIDTH = 12,
   localparam int unsigned IDX_W = idx_bits(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_half,
   input  logic             decide,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             cmp_above,
   output logic [WIDTH-1:0] trial_q,
   output logic [WIDTH-1:0] trial_d
);

   localparam logic [WIDTH-1:0] HALF_CODE = WIDTH'(1) << (WIDTH - 1);

   always_comb begin
      trial_d          = trial_q;
      trial_d[bit_idx] = cmp_above;
      if (bit_idx != '0) trial_d[bit_idx - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         trial_q <= '0;
      else if (load_half) trial_q <= HALF_CODE;
      else if (decide)    trial_q <= trial_d;
   end

   logic [WIDTH-1:0] cur_bit;
   logic [WIDTH-1:0] upto_mask;
   assign cur_bit   = WIDTH'(1) << bit_idx;
   assign upto_mask = cur_bit | (cur_bit - 1'b1);

   // R4: when a bit is under trial it is set and every lower bit is clear
   a_r4_trial_shape: assert property (@(posedge clk) disable iff (!rst_n)
      decide |-> ((trial_q & upto_mask) == cur_bit));

endmodule

// File: rtl/sar_seq_hold.sv
module sar_seq_hold #(
   parameter int unsigned WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_stb,
   input  logic [WIDTH-1:0] final_code,
   output logic [WIDTH-1:0] result_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        result_q <= '0;
      else if (done_stb) result_q <= final_code;
   end

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
   import sar_seq_pkg::*;
#(
   parameter int unsigned WIDTH         = 12,
   parameter int unsigned SETTLE_CYCLES = 1,
   localparam int unsigned IDX_W        = idx_bits(WIDTH),
   localparam int unsigned BUSY_EDGES   = SETTLE_CYCLES + WIDTH,
   localparam int unsigned BCNT_W       = $clog2(BUSY_EDGES + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             cmp_above,
   output logic [WIDTH-1:0] trial_code,
   output logic             busy_n,
   output logic [WIDTH-1:0] result
);

   localparam logic [WIDTH-1:0] HALF_CODE = WIDTH'(1) << (WIDTH - 1);

   initial begin
      if (WIDTH < 2)
         $error("sar_conv_sequencer: WIDTH must be at least 2");
      if (SETTLE_CYCLES < 1)
         $error("sar_conv_sequencer: SETTLE_CYCLES must be at least 1");
   end

   logic             busy_q, load_half, decide, done_stb;
   logic [IDX_W-1:0] bit_idx;
   logic [WIDTH-1:0] trial_q, trial_d;

   sar_seq_timer #(.WIDTH(WIDTH), .SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .busy_q    (busy_q),
      .load_half (load_half),
      .decide    (decide),
      .done_stb  (done_stb),
      .bit_idx   (bit_idx)
   );

   sar_seq_trial #(.WIDTH(WIDTH)) u_trial (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_half (load_half),
      .decide    (decide),
      .bit_idx   (bit_idx),
      .cmp_above (cmp_above),
      .trial_q   (trial_q),
      .trial_d   (trial_d)
   );

   sar_seq_hold #(.WIDTH(WIDTH)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_stb   (done_stb),
      .final_code (trial_d),
      .result_q   (result)
   );

   // Request preset takes effect without waiting for an edge
   assign trial_code = load_half ? HALF_CODE : trial_q;
   assign busy_n     = !(busy_q || load_half);

   // Edge counter used only by the length check
   logic [BCNT_W-1:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_q) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   // R3: the registered trial enters the conversion at half scale
   a_r3_half_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (trial_q == HALF_CODE));

   // R6: finishing edge releases busy and the holding register matches the trial
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> (!busy_q && result == trial_q));

   // R7: a conversion never outlasts its fixed number of edges
   a_r7_length: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (busy_cnt < BCNT_W'(BUSY_EDGES)));

endmodule

// File: tb/sar_conv_sequencer_tb_top.sv
module sar_conv_sequencer_tb_top;

   localparam int W = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_req = 1'b0;
   logic [W-1:0]  ain = '0;
   logic          cmp_above;
   logic [W-1:0]  trial_code;
   logic          busy_n;
   logic [W-1:0]  result;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // Ideal comparator model: a tie clears the bit
   assign cmp_above = (ain > trial_code);

   sar_conv_sequencer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .cmp_above  (cmp_above),
      .trial_code (trial_code),
      .busy_n     (busy_n),
      .result     (result)
   );

   // {input, expected result}
   localparam logic [23:0] VECS [8] = '{
      {12'h000, 12'h000}, {12'h001, 12'h000}, {12'h800, 12'h7FF}, {12'h801, 12'h800},
      {12'hFFF, 12'hFFE}, {12'h555, 12'h554}, {12'hA5A, 12'hA59}, {12'h123, 12'h122}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Run one conversion; stray = falling edge at which to pulse an ignored request (0 = none)
   task automatic convert(input logic [W-1:0] v, input logic [W-1:0] exp_res,
                          input int stray, input bit already_neg);
      logic [W-1:0] old_res;
      logic [W-1:0] second;
      if (!already_neg) @(negedge clk);
      old_res   = result;
      ain       = v;
      start_req = 1'b1;
      #1;
      check("R2 busy_n low in request cycle", W'(busy_n), W'(0));
      check("R2 half-scale trial", trial_code, 12'h800);
      second = (v > 12'h800) ? 12'hC00 : 12'h400;
      for (int k = 1; k <= 13; k++) begin
         @(negedge clk);
         start_req = (stray != 0 && k == stray);
         #1;
         if (k == 1) check("R3 half scale after first edge", trial_code, 12'h800);
         if (k == 2) check("R4 second trial", trial_code, second);
         if (k == 12) begin
            check("R7 busy_n still low at edge 12", W'(busy_n), W'(0));
            check("R6 old result held", result, old_res);
         end
         if (k == 13) begin
            check("R7 busy_n high after 13 periods", W'(busy_n), W'(1));
            check("R5 result", result, exp_res);
         end
      end
      start_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 busy_n after reset", W'(busy_n), W'(1));
      check("R1 result after reset", result, '0);
      check("R1 trial_code after reset", trial_code, '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table of vectors, R5 coding
      for (int i = 0; i < 8; i++) begin
         convert(VECS[i][23:12], VECS[i][11:0], 0, 1'b0);
         @(negedge clk);
      end

      // R8: stray request mid-conversion is ignored
      convert(12'h3C4, 12'h3C3, 5, 1'b0);
      #1;
      check("R8 stays idle after ignored request", W'(busy_n), W'(1));
      check("R8 result unchanged after finish", result, 12'h3C3);

      // R8: stray request on the edge that finishes is ignored too
      @(negedge clk);
      convert(12'h0F0, 12'h0EF, 12, 1'b0);

      // R9: request right after release is accepted
      convert(12'h7FF, 12'h7FE, 0, 1'b1);
      check("R9 back-to-back result", result, 12'h7FE);

      // R1: reset in the middle of a conversion clears everything
      @(negedge clk);
      ain = 12'hABC;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 busy_n on mid-run reset", W'(busy_n), W'(1));
      check("R1 result on mid-run reset", result, '0);
      @(negedge clk);
      rst_n = 1'b1;
      convert(12'hABC, 12'hABB, 0, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule